// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the slave-side physical layer of a single-wire, open-drain bus. It runs from a fast system clock and watches a synchronized copy of the line. On each falling edge made by the master it starts a timer. That timer decides when the line is sampled to recover a written bit. When the upper layer has a 0 to return in a read slot, the timer also decides how long the block holds the line low. The block measures every low pulse, so it can tell when a pulse is long enough to be a bus reset. It answers each reset with a presence pulse, and the presence pulse is the only low pulse that the slave starts on its own.

There are two timing sets, standard and overdrive. The upper layer moves the engine into overdrive with a one-cycle request after it has decoded the matching command. Only a reset takes the engine out again. A short reset while in overdrive keeps overdrive. A long reset returns to standard speed. When a reset in overdrive lies between the keep limit and the standard reset length, the speed is otherwise undefined, and this engine resolves it to standard speed. Every time value is a parameter counted in clock cycles.

Top module: `swire_slave_phy`

## Requirements
- R1: After reset, line_pull, rx_valid, rst_pulse and od_active are all 0.
- R2: At standard speed the line level is sampled STD_SAMPLE clock edges after the first edge that sees the line low. rx_valid then pulses for one cycle, and rx_bit is 1 if the line was high and 0 if it was low. A low time of STD_SAMPLE cycles or less therefore gives 1, and a longer one gives 0.
- R3: If tx_en=1 and tx_bit=0 when a falling edge is seen, line_pull is high for exactly the hold length of the current speed (STD_HOLD or OD_HOLD cycles), beginning with the cycle after that edge.
- R4: If tx_en=0, or tx_bit=1, at the falling edge, line_pull stays 0 for the whole slot.
- R5: A low time of at least the reset length of the current speed (STD_RST, or OD_RST in overdrive), counted in clock edges that see the line low, gives one rst_pulse cycle when the line rises. A low time one cycle shorter is handled as a plain slot and gives neither rst_pulse nor a presence pulse.
- R6: After a reset, line_pull rises at the PDH-th clock edge after the edge that saw the line high, and stays high for PDL cycles. PDH and PDL are taken from the speed that holds after the reset has been classified.
- R7: A one-cycle od_set makes od_active 1 from the next cycle. From then on, slots use OD_SAMPLE and OD_HOLD.
- R8: In overdrive, a reset low time of at most OD_KEEP cycles keeps od_active at 1. Any longer reset clears od_active.
- R9: If od_set arrives in the same cycle that the rising edge of a reset is seen, the reset classification wins. A reset long enough to end overdrive leaves od_active at 0.
- R10: od_active rises only in the cycle after an od_set, and falls only together with rst_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Synchronized bus level (1 = released/high) |
| od_set | input | 1 | One-cycle request to enter overdrive timing |
| tx_en | input | 1 | Respond in the next slot with tx_bit |
| tx_bit | input | 1 | Bit to return in a read slot (0 pulls low) |
| line_pull | output | 1 | Drive the bus low when 1 |
| rx_valid | output | 1 | One-cycle strobe for a sampled bit |
| rx_bit | output | 1 | Sampled line level of the slot |
| rst_pulse | output | 1 | One-cycle strobe when a reset pulse ends |
| od_active | output | 1 | Overdrive timing in use |

## Verification
Two things can land on the same clock edge: the classification of a reset that ends overdrive, and an od_set request from the upper layer. The bench provokes this by raising od_set on exactly the cycle the master releases a long reset. The design passes only if od_active is still 0 afterwards and the presence pulse that follows uses standard timing. The bench also drives the reset and sample thresholds at their exact edge lengths at both speeds. Between those directed cases it runs seeded random write and read slots.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SLOT,
    PH_PRES,
    PH_DRAIN
  } phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swire_timing_sel.sv
module swire_timing_sel #(
  parameter int unsigned CW         = 16,
  parameter bit          OD_SUPPORT = 1'b1,
  parameter int unsigned STD_SAMPLE = 1500,
  parameter int unsigned STD_HOLD   = 1500,
  parameter int unsigned STD_PDH    = 1500,
  parameter int unsigned STD_PDL    = 6000,
  parameter int unsigned OD_SAMPLE  = 150,
  parameter int unsigned OD_HOLD    = 150,
  parameter int unsigned OD_PDH     = 100,
  parameter int unsigned OD_PDL     = 400
) (
  input  logic          od_slot,
  input  logic          od_pres,
  output logic [CW-1:0] sample_at,
  output logic [CW-1:0] hold_len,
  output logic [CW-1:0] pdh_len,
  output logic [CW-1:0] pdl_len
);

  generate
    if (OD_SUPPORT) begin : g_dual
      assign sample_at = od_slot ? CW'(OD_SAMPLE) : CW'(STD_SAMPLE);
      assign hold_len  = od_slot ? CW'(OD_HOLD)   : CW'(STD_HOLD);
      assign pdh_len   = od_pres ? CW'(OD_PDH)    : CW'(STD_PDH);
      assign pdl_len   = od_pres ? CW'(OD_PDL)    : CW'(STD_PDL);
    end else begin : g_single
      logic unused_od;
      assign unused_od = od_slot ^ od_pres;
      assign sample_at = CW'(STD_SAMPLE);
      assign hold_len  = CW'(STD_HOLD);
      assign pdh_len   = CW'(STD_PDH);
      assign pdl_len   = CW'(STD_PDL);
    end
  endgenerate

endmodule

// File: rtl/swire_reset_class.sv
module swire_reset_class #(
  parameter int unsigned CW      = 16,
  parameter int unsigned STD_RST = 24000,
  parameter int unsigned OD_RST  = 2400,
  parameter int unsigned OD_KEEP = 4000
) (
  input  logic          od,
  input  logic [CW-1:0] low_len,
  output logic          is_rst,
  output logic          od_after
);

  logic long_std;
  logic long_od;
  logic short_keep;

  assign long_std   = (low_len >= CW'(STD_RST));
  assign long_od    = (low_len >= CW'(OD_RST));
  assign short_keep = (low_len <= CW'(OD_KEEP));

  always_comb begin
    if (od) begin
      is_rst   = long_od;
      od_after = short_keep && !long_std;
    end else begin
      is_rst   = long_std;
      od_after = 1'b0;
    end
  end

endmodule

// File: rtl/swire_pres_gen.sv
module swire_pres_gen #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] pdh_len,
  input  logic [CW-1:0] pdl_len,
  output logic          pull,
  output logic          done
);

  typedef enum logic [1:0] {PG_IDLE, PG_GAP, PG_DRIVE} pg_e;

  pg_e           ph_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pdh_q;
  logic [CW-1:0] pdl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PG_IDLE;
      cnt_q <= '0;
      pdh_q <= '0;
      pdl_q <= '0;
      pull  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PG_IDLE: begin
          if (start) begin
            ph_q  <= PG_GAP;
            cnt_q <= CW'(1);
            pdh_q <= pdh_len;
            pdl_q <= pdl_len;
          end
        end
        PG_GAP: begin
          if (cnt_q >= pdh_q) begin
            ph_q  <= PG_DRIVE;
            pull  <= 1'b1;
            cnt_q <= CW'(1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PG_DRIVE: begin
          if (cnt_q >= pdl_q) begin
            ph_q <= PG_IDLE;
            pull <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ph_q <= PG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swire_slave_phy.sv
module swire_slave_phy
  import swire_pkg::*;
#(
  parameter bit          OD_SUPPORT = 1'b1,
  parameter int unsigned STD_SAMPLE = 1500,
  parameter int unsigned STD_HOLD   = 1500,
  parameter int unsigned STD_RST    = 24000,
  parameter int unsigned STD_PDH    = 1500,
  parameter int unsigned STD_PDL    = 6000,
  parameter int unsigned OD_SAMPLE  = 150,
  parameter int unsigned OD_HOLD    = 150,
  parameter int unsigned OD_RST     = 2400,
  parameter int unsigned OD_KEEP    = 4000,
  parameter int unsigned OD_PDH     = 100,
  parameter int unsigned OD_PDL     = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic od_set,
  input  logic tx_en,
  input  logic tx_bit,
  output logic line_pull,
  output logic rx_valid,
  output logic rx_bit,
  output logic rst_pulse,
  output logic od_active
);

  localparam int unsigned MAXV = umax(umax(STD_RST, OD_KEEP),
                                      umax(STD_PDL, umax(STD_PDH + OD_PDL,
                                      STD_SAMPLE + STD_HOLD))) + 2;
  localparam int unsigned CW   = $clog2(MAXV) + 1;
  localparam logic [CW-1:0] CNT_TOP = '1;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          rose_q;
  logic          zero_q;
  logic          slot_pull_q;
  logic          od_q;

  logic [CW-1:0] sample_at;
  logic [CW-1:0] hold_len;
  logic [CW-1:0] pdh_len;
  logic [CW-1:0] pdl_len;
  logic          is_rst;
  logic          od_after;
  logic          rst_evt;
  logic          pres_pull;
  logic          pres_done;
  logic          send_zero;

  swire_timing_sel #(
    .CW(CW), .OD_SUPPORT(OD_SUPPORT),
    .STD_SAMPLE(STD_SAMPLE), .STD_HOLD(STD_HOLD),
    .STD_PDH(STD_PDH), .STD_PDL(STD_PDL),
    .OD_SAMPLE(OD_SAMPLE), .OD_HOLD(OD_HOLD),
    .OD_PDH(OD_PDH), .OD_PDL(OD_PDL)
  ) u_tsel (
    .od_slot  (od_q),
    .od_pres  (od_after),
    .sample_at(sample_at),
    .hold_len (hold_len),
    .pdh_len  (pdh_len),
    .pdl_len  (pdl_len)
  );

  swire_reset_class #(
    .CW(CW), .STD_RST(STD_RST), .OD_RST(OD_RST), .OD_KEEP(OD_KEEP)
  ) u_rcls (
    .od      (od_q),
    .low_len (cnt_q),
    .is_rst  (is_rst),
    .od_after(od_after)
  );

  // a reset ends at the first high level seen after a long enough low run
  assign rst_evt   = (ph_q == PH_SLOT) && !rose_q && line_in && is_rst;
  assign send_zero = tx_en && !tx_bit;

  swire_pres_gen #(.CW(CW)) u_pres (
    .clk    (clk),
    .rst    (rst),
    .start  (rst_evt),
    .pdh_len(pdh_len),
    .pdl_len(pdl_len),
    .pull   (pres_pull),
    .done   (pres_done)
  );

  // speed register: reset classification has priority over an upper-layer request
  always_ff @(posedge clk) begin
    if (rst) begin
      od_q <= 1'b0;
    end else if (rst_evt) begin
      od_q <= od_after;
    end else if (od_set && OD_SUPPORT) begin
      od_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      rose_q      <= 1'b0;
      zero_q      <= 1'b0;
      slot_pull_q <= 1'b0;
      rx_valid    <= 1'b0;
      rx_bit      <= 1'b0;
      rst_pulse   <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      rst_pulse <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (!line_in) begin
            ph_q        <= PH_SLOT;
            cnt_q       <= CW'(1);
            rose_q      <= 1'b0;
            zero_q      <= send_zero;
            slot_pull_q <= send_zero;
          end
        end
        PH_SLOT: begin
          if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + CW'(1);
          end
          if (cnt_q == sample_at) begin
            rx_valid <= 1'b1;
            rx_bit   <= line_in;
          end
          slot_pull_q <= zero_q && (cnt_q < hold_len);
          if (rose_q && (cnt_q > sample_at) && (cnt_q > hold_len)) begin
            ph_q <= PH_IDLE;
          end
          if (!rose_q && line_in) begin
            if (rst_evt) begin
              ph_q        <= PH_PRES;
              rst_pulse   <= 1'b1;
              slot_pull_q <= 1'b0;
            end else begin
              rose_q <= 1'b1;
            end
          end
        end
        PH_PRES: begin
          if (pres_done) begin
            ph_q <= PH_DRAIN;
          end
        end
        PH_DRAIN: begin
          if (line_in) begin
            ph_q <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign line_pull = slot_pull_q | pres_pull;
  assign od_active = od_q;

endmodule

// File: rtl/swire_slave_phy_chk.sv
module swire_slave_phy_chk (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic od_set,
  input logic line_pull,
  input logic rx_valid,
  input logic rst_pulse,
  input logic od_active
);

  // R2
  rx_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  rst_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> $past(line_in));

  // R6
  pres_not_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> !line_pull);

  // R10
  od_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(od_active) |-> $past(od_set));

  // R10
  od_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(od_active) |-> rst_pulse);

endmodule

bind swire_slave_phy swire_slave_phy_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .line_in  (line_in),
  .od_set   (od_set),
  .line_pull(line_pull),
  .rx_valid (rx_valid),
  .rst_pulse(rst_pulse),
  .od_active(od_active)
);

// File: tb/swire_slave_phy_bench.sv
module swire_slave_phy_bench;

  localparam int S_SMP = 20, S_HLD = 20, S_RST = 200, S_PDH = 15, S_PDL = 60;
  localparam int O_SMP = 4,  O_HLD = 4,  O_RST = 40,  O_KEEP = 60, O_PDH = 3, O_PDL = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic od_set = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b1;
  logic line_in;
  logic line_pull, rx_valid, rx_bit, rst_pulse, od_active;

  int compared = 0;
  int mismatched = 0;

  int n_rx, last_rx, pull_cnt, first_pull, n_rst;

  always #10 clk = ~clk;

  assign line_in = !(master_low || line_pull);

  swire_slave_phy #(
    .STD_SAMPLE(S_SMP), .STD_HOLD(S_HLD), .STD_RST(S_RST),
    .STD_PDH(S_PDH), .STD_PDL(S_PDL),
    .OD_SAMPLE(O_SMP), .OD_HOLD(O_HLD), .OD_RST(O_RST),
    .OD_KEEP(O_KEEP), .OD_PDH(O_PDH), .OD_PDL(O_PDL)
  ) u_swire_slave_phy (
    .clk(clk), .rst(rst), .line_in(line_in), .od_set(od_set),
    .tx_en(tx_en), .tx_bit(tx_bit), .line_pull(line_pull),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rst_pulse(rst_pulse),
    .od_active(od_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bit(input int low_len, input int smp);
    return (low_len <= smp) ? 1 : 0;
  endfunction

  function automatic int exp_od_after(input int od, input int low_len);
    if (od != 0 && low_len <= O_KEEP && low_len < S_RST) return 1;
    return 0;
  endfunction

  task automatic smp(input int j);
    if (rx_valid) begin
      n_rx++;
      last_rx = int'(rx_bit);
    end
    if (line_pull) begin
      pull_cnt++;
      if (first_pull < 0 && j > 0) first_pull = j;
    end
    if (rst_pulse) n_rst++;
  endtask

  task automatic slot(input int low_len, input int rec, input bit te,
                      input bit tb, input bit ods);
    n_rx = 0; last_rx = -1; pull_cnt = 0; first_pull = -1; n_rst = 0;
    tx_en = te; tx_bit = tb;
    @(negedge clk);
    master_low = 1'b1;
    for (int i = 0; i < low_len; i++) begin
      @(negedge clk);
      smp(0);
    end
    master_low = 1'b0;
    od_set = ods;
    for (int j = 1; j <= rec; j++) begin
      @(negedge clk);
      smp(j);
      if (j == 1) od_set = 1'b0;
    end
    tx_en = 1'b0; tx_bit = 1'b1;
  endtask

  task automatic go_od();
    @(negedge clk);
    od_set = 1'b1;
    @(negedge clk);
    od_set = 1'b0;
  endtask

  task automatic write_chk(input string req, input int low_len, input int rec, input int smpv);
    slot(low_len, rec, 1'b0, 1'b1, 1'b0);
    chk(req, n_rx, 1);
    chk(req, last_rx, exp_bit(low_len, smpv));
    chk(req, pull_cnt, 0);
    chk(req, n_rst, 0);
  endtask

  task automatic reset_chk(input string req, input int low_len, input int od_before, input bit ods);
    int oda;
    oda = exp_od_after(od_before, low_len);
    slot(low_len, 100, 1'b0, 1'b1, ods);
    chk(req, n_rst, 1);
    chk(req, int'(od_active), oda);
    chk(req, first_pull, (oda != 0 ? O_PDH : S_PDH) + 1);
    chk(req, pull_cnt, oda != 0 ? O_PDL : S_PDL);
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    int kind, len;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(line_pull), 0);
    chk("R1", int'(rx_valid), 0);
    chk("R1", int'(rst_pulse), 0);
    chk("R1", int'(od_active), 0);

    // R2 sample boundary at standard speed
    write_chk("R2", S_SMP, 30, S_SMP);
    write_chk("R2", S_SMP + 1, 30, S_SMP);
    write_chk("R2", 2, 30, S_SMP);

    // R3 read zero at standard speed
    slot(2, 30, 1'b1, 1'b0, 1'b0);
    chk("R3", pull_cnt, S_HLD);
    chk("R3", last_rx, 0);
    // R4 read one and disabled response
    slot(2, 30, 1'b1, 1'b1, 1'b0);
    chk("R4", pull_cnt, 0);
    chk("R4", last_rx, 1);
    slot(2, 30, 1'b0, 1'b0, 1'b0);
    chk("R4", pull_cnt, 0);

    // R5 standard reset threshold
    slot(S_RST - 1, 100, 1'b0, 1'b1, 1'b0);
    chk("R5", n_rst, 0);
    chk("R5", pull_cnt, 0);
    reset_chk("R5", S_RST, 0, 1'b0);
    // R6 standard presence timing on a longer reset
    reset_chk("R6", S_RST + 37, 0, 1'b0);

    // R7 entering overdrive and its slot timing
    go_od();
    chk("R7", int'(od_active), 1);
    write_chk("R7", O_SMP, 12, O_SMP);
    write_chk("R7", O_SMP + 1, 12, O_SMP);
    slot(1, 12, 1'b1, 1'b0, 1'b0);
    chk("R7", pull_cnt, O_HLD);

    // R5 overdrive reset threshold
    slot(O_RST - 1, 100, 1'b0, 1'b1, 1'b0);
    chk("R5", n_rst, 0);
    chk("R5", int'(od_active), 1);
    // R8 keep overdrive on a short reset, including the keep boundary
    reset_chk("R8", O_RST, 1, 1'b0);
    reset_chk("R8", O_KEEP, 1, 1'b0);
    chk("R8", int'(od_active), 1);
    // R8 middle-length reset resolves to standard
    reset_chk("R8", O_KEEP + 1, 1, 1'b0);
    chk("R8", int'(od_active), 0);

    // R9 od_set coinciding with the end of a long reset
    go_od();
    chk("R9", int'(od_active), 1);
    reset_chk("R9", S_RST + 5, 1, 1'b1);
    chk("R9", int'(od_active), 0);
    // R10 od_set alone while idle raises the flag; reset-free slots keep it
    go_od();
    write_chk("R10", 3, 12, O_SMP);
    chk("R10", int'(od_active), 1);
    reset_chk("R10", S_RST, 1, 1'b0);

    // random standard-speed slots (R2 R3 R4)
    for (int k = 0; k < 60; k++) begin
      kind = int'($urandom % 4);
      if (kind == 0) begin
        len = 1 + int'($urandom % (S_SMP - 2));
        write_chk("R2", len, 30, S_SMP);
      end else if (kind == 1) begin
        len = S_SMP + 1 + int'($urandom % (S_RST - S_SMP - 2));
        write_chk("R2", len, 30, S_SMP);
      end else begin
        len = 1 + int'($urandom % 3);
        slot(len, 30, 1'b1, kind == 3, 1'b0);
        chk(kind == 2 ? "R3" : "R4", pull_cnt, kind == 2 ? S_HLD : 0);
        chk(kind == 2 ? "R3" : "R4", last_rx, kind == 2 ? 0 : 1);
      end
    end

    // random overdrive slots (R7 R3 R4)
    go_od();
    for (int k = 0; k < 60; k++) begin
      kind = int'($urandom % 4);
      if (kind == 0) begin
        len = 1 + int'($urandom % O_SMP);
        write_chk("R7", len, 12, O_SMP);
      end else if (kind == 1) begin
        len = O_SMP + 1 + int'($urandom % (O_RST - O_SMP - 2));
        write_chk("R7", len, 12, O_SMP);
      end else begin
        len = 1 + int'($urandom % 2);
        slot(len, 12, 1'b1, kind == 3, 1'b0);
        chk(kind == 2 ? "R3" : "R4", pull_cnt, kind == 2 ? O_HLD : 0);
        chk(kind == 2 ? "R3" : "R4", last_rx, kind == 2 ? 0 : 1);
      end
    end
    chk("R10", int'(od_active), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule